// File: doc/BRIEF.md
# Block-in-Block-out Reorder Queue

This queue moves whole blocks of words from a producing pipeline stage to a consuming one. Blocks leave in the order they went in, but inside a block each side can touch words in any order. The producer writes words by offset into the block it is filling and then commits that block with a push that states its size. Until the push, the consumer cannot see the block. The consumer reads words by offset from the oldest committed block and then releases it with a pull. The pull states its own size.

Words are kept in a circular on-chip array. Both sides use the same scan order for word offsets and for block succession, so a merged block always sits in contiguous storage. Four pushed sub-blocks can therefore be pulled as one larger block, and one pushed block can be pulled as four smaller ones, without any copying. A block size is a power of four words: 1, 4, 16 or 64. It is carried as a 2-bit code that holds the base-4 log of the size, so code 0 means 1 word, code 1 means 4, code 2 means 16 and code 3 means 64.

Top module: `bibo_queue`

## Requirements
- R1: After reset the committed count is 0, the free count is 256, the error flag is 0, `push_ready` is 1 for a one-word block and `pull_ready` is 0.
- R2: A write with `wr_en` high and `wr_off` below the size given by `push_size` stores `wr_data` at the write base plus the offset, modulo 256. Offsets may be written in any order.
- R3: A push is taken only when the free count is at least 4^`push_size`, and `push_ready` shows this. A push that is not taken leaves both counters unchanged.
- R4: A pull is taken only when the committed count is at least 4^`pull_size`, and `pull_ready` shows this. A pull that is not taken leaves both counters unchanged.
- R5: Committed blocks reach the consumer in first-in-first-out order. A read at offset k returns the k-th word after the read base.
- R6: A taken push adds its size to the committed count and removes it from the free count. A taken pull does the reverse. The two counts always add up to 256.
- R7: `rd_data` holds the addressed word on the clock edge after `rd_en` is presented. It keeps its value in every cycle in which no read is taken.
- R8: A write offset at or above the push size, or a read offset at or above the pull size, is ignored and sets a sticky error flag. Only reset clears the flag.
- R9: Four blocks pushed at one size can be pulled as a single block of the next size up, and their words appear in push order.
- R10: One block pushed at one size can be pulled as four blocks of the next size down, each covering the matching quarter.
- R11: A write and a read to different addresses in the same cycle are both carried out.
- R12: Both bases wrap modulo 256, so blocks that cross the end of the array are stored and returned intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write one word of the block being filled |
| wr_off | input | 6 | Word offset of the write within the block |
| wr_data | input | DW | Word to write |
| push_size | input | 2 | Base-4 log size of the block being filled and pushed |
| push_valid | input | 1 | Request to commit the filled block |
| push_ready | output | 1 | Enough free space for the push |
| rd_en | input | 1 | Read one word of the head block |
| rd_off | input | 6 | Word offset of the read within the head block |
| rd_data | output | DW | Read word, valid one cycle after the request |
| pull_size | input | 2 | Base-4 log size of the head block being read and pulled |
| pull_valid | input | 1 | Request to release the head block |
| pull_ready | output | 1 | Enough committed words for the pull |
| used_words | output | AW+1 | Committed word count |
| free_words | output | AW+1 | Free word count |
| err | output | 1 | Sticky flag for an out-of-range offset |

## Verification
On every cycle the assertions check four things: the two counters always balance, refused pushes and pulls leave the counters unchanged, a taken push raises the committed count by exactly its size, and the error flag and the read register never change without cause. Data ordering cannot be checked that way. That covers reordered writes, merging and splitting across every pair of push and pull sizes, wrap of the bases, same-cycle write and read, and discarded out-of-range writes. The bench's sweeps show these against a word-level model of the queue contents.

// File: rtl/bibo_queue.sv
module bibo_queue #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [5:0]    wr_off,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    push_size,
  input  logic          push_valid,
  output logic          push_ready,
  input  logic          rd_en,
  input  logic [5:0]    rd_off,
  output logic [DW-1:0] rd_data,
  input  logic [1:0]    pull_size,
  input  logic          pull_valid,
  output logic          pull_ready,
  output logic [AW:0]   used_words,
  output logic [AW:0]   free_words,
  output logic          err
);
  localparam int DEPTH = 1 << AW;

  function automatic logic [AW:0] blk_words(input logic [1:0] s);
    return (AW+1)'(1) << (2 * s);
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_base, rd_base;
  logic [AW:0]   push_n, pull_n;
  logic          wr_ok, rd_ok, push_go, pull_go;

  assign push_n     = blk_words(push_size);
  assign pull_n     = blk_words(pull_size);
  assign wr_ok      = wr_en && ((AW+1)'(wr_off) < push_n);
  assign rd_ok      = rd_en && ((AW+1)'(rd_off) < pull_n);
  assign push_ready = free_words >= push_n;
  assign pull_ready = used_words >= pull_n;
  assign push_go    = push_valid && push_ready;
  assign pull_go    = pull_valid && pull_ready;

  always_ff @(posedge clk)
    if (wr_ok) mem[wr_base + AW'(wr_off)] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_data    <= '0;
      wr_base    <= '0;
      rd_base    <= '0;
      used_words <= '0;
      free_words <= (AW+1)'(DEPTH);
      err        <= 1'b0;
    end else begin
      if (rd_ok) rd_data <= mem[rd_base + AW'(rd_off)];
      if (push_go) wr_base <= wr_base + AW'(push_n);
      if (pull_go) rd_base <= rd_base + AW'(pull_n);
      used_words <= used_words + (push_go ? push_n : '0) - (pull_go ? pull_n : '0);
      free_words <= free_words - (push_go ? push_n : '0) + (pull_go ? pull_n : '0);
      err        <= err | (wr_en && !wr_ok) | (rd_en && !rd_ok);
    end
endmodule

// File: rtl/bibo_queue_chk.sv
module bibo_queue_chk #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    push_size,
  input logic          push_valid,
  input logic          push_ready,
  input logic          pull_valid,
  input logic          pull_ready,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic [AW:0]   used_words,
  input logic [AW:0]   free_words,
  input logic          err
);
  localparam int DEPTH = 1 << AW;

  function automatic logic [AW:0] sz(input logic [1:0] s);
    return (AW+1)'(1) << (2 * s);
  endfunction

  // R6
  balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(used_words) + int'(free_words)) == DEPTH);

  // R3
  push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready && !(pull_valid && pull_ready)) |=> $stable(free_words));

  // R4
  pull_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_valid && !pull_ready && !(push_valid && push_ready)) |=> $stable(used_words));

  // R6
  push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_ready && !(pull_valid && pull_ready))
      |=> used_words == $past(used_words) + $past(sz(push_size)));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind bibo_queue bibo_queue_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_size(push_size), .push_valid(push_valid),
  .push_ready(push_ready), .pull_valid(pull_valid), .pull_ready(pull_ready),
  .rd_en(rd_en), .rd_data(rd_data), .used_words(used_words),
  .free_words(free_words), .err(err)
);

// File: tb/test_bibo_queue.sv
module test_bibo_queue;
  localparam int CLK_P = 10;
  localparam int DW = 16;
  localparam int AW = 8;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, push_valid = 0, pull_valid = 0;
  logic [5:0] wr_off = 0, rd_off = 0;
  logic [DW-1:0] wr_data = 0;
  logic [1:0] push_size = 0, pull_size = 0;
  logic push_ready, pull_ready, err;
  logic [DW-1:0] rd_data;
  logic [AW:0] used_words, free_words;

  int checks = 0, failures = 0, tag = 0;
  int mq[$];

  always #(CLK_P/2) clk = ~clk;

  bibo_queue #(.DW(DW), .AW(AW)) i_bibo_queue (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int off, input int d);
    @(negedge clk); wr_en = 1; wr_off = 6'(off); wr_data = DW'(d);
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(input int off, output int d);
    @(negedge clk); rd_en = 1; rd_off = 6'(off);
    @(posedge clk); #1 rd_en = 0; d = int'(rd_data);
  endtask

  task automatic do_push(input int s, input string req);
    @(negedge clk); push_size = 2'(s); push_valid = 1;
    #1 check({req, " push_ready"}, int'(push_ready), int'(int'(free_words) >= (1 << 2*s)));
    @(posedge clk); #1 push_valid = 0;
    check({req, " R6 used after push"}, int'(used_words), mq.size());
    check({req, " R6 free after push"}, int'(free_words), 256 - mq.size());
  endtask

  task automatic do_pull(input int s, input string req);
    @(negedge clk); pull_size = 2'(s); pull_valid = 1;
    #1 check({req, " pull_ready"}, int'(pull_ready), int'(int'(used_words) >= (1 << 2*s)));
    @(posedge clk); #1 pull_valid = 0;
    check({req, " R6 used after pull"}, int'(used_words), mq.size());
  endtask

  task automatic fill_block(input int s);
    int n = 1 << 2*s;
    push_size = 2'(s);
    for (int i = 0; i < n; i++) begin
      int off = (i * 5 + 3) % n;
      wr(off, (tag << 6) | off);
    end
    for (int i = 0; i < n; i++) mq.push_back(((tag << 6) | i) & 16'hffff);
    tag++;
    do_push(s, "R3");
  endtask

  task automatic drain_block(input int s, input string req);
    int n = 1 << 2*s;
    int d;
    pull_size = 2'(s);
    for (int i = 0; i < n; i++) begin
      int off = (i * 3 + 1) % n;
      rd(off, d);
      check({req, " R2 R5 R7 word"}, d, mq[off]);
    end
    for (int i = 0; i < n; i++) void'(mq.pop_front());
    do_pull(s, "R4");
  endtask

  initial begin
    #(CLK_P * 200000);
    failures++;
    $display("FAIL R5 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int d, v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 used", int'(used_words), 0);
    check("R1 free", int'(free_words), 256);
    check("R1 err", int'(err), 0);
    check("R1 push_ready", int'(push_ready), 1);
    check("R1 pull_ready", int'(pull_ready), 0);

    // R9 R10 R12: every push/pull size pair, 64 words each, bases wrap
    for (int ps = 0; ps < 4; ps++)
      for (int qs = 0; qs < 4; qs++) begin
        string req = (ps < qs) ? "R9" : (ps > qs) ? "R10" : "R5";
        for (int b = 0; b < (64 >> 2*ps); b++) fill_block(ps);
        for (int b = 0; b < (64 >> 2*qs); b++) drain_block(qs, {req, " R12"});
      end
    check("R8 err clean", int'(err), 0);

    // R11: write into filling block while reading head block
    fill_block(1);
    @(negedge clk);
    push_size = 1; pull_size = 1;
    wr_en = 1; wr_off = 0; wr_data = 16'h5a5a;
    rd_en = 1; rd_off = 2;
    @(posedge clk); #1 wr_en = 0; rd_en = 0;
    check("R11 read beside write", int'(rd_data), mq[2]);
    for (int i = 1; i < 4; i++) wr(i, 16'h5a50 + i);
    mq.push_back(16'h5a5a);
    for (int i = 1; i < 4; i++) mq.push_back(16'h5a50 + i);
    do_push(1, "R11");
    drain_block(1, "R11");
    drain_block(1, "R11");

    // R8: out-of-range write ignored
    push_size = 2; wr(5, 16'h1111);
    push_size = 1; wr(5, 16'h2222);
    check("R8 err after bad write", int'(err), 1);
    push_size = 2;
    for (int i = 0; i < 16; i++) if (i != 5) wr(i, 16'h3300 + i);
    for (int i = 0; i < 16; i++) mq.push_back(i == 5 ? 16'h1111 : 16'h3300 + i);
    do_push(2, "R8");
    pull_size = 2; rd(0, v);
    check("R8 first word", v, mq[0]);
    pull_size = 0; rd(3, d);
    check("R8 bad read leaves rd_data", d, v);
    check("R8 err stays", int'(err), 1);
    drain_block(2, "R8");

    // R3 R4 R12: fill to full, refuse, drain to empty, refuse
    for (int b = 0; b < 4; b++) fill_block(3);
    check("R3 R12 full used", int'(used_words), 256);
    @(negedge clk); push_size = 0; push_valid = 1;
    #1 check("R3 push_ready full", int'(push_ready), 0);
    @(posedge clk); #1 push_valid = 0;
    check("R3 free unchanged", int'(free_words), 0);
    for (int b = 0; b < 4; b++) drain_block(3, "R12");
    @(negedge clk); pull_size = 0; pull_valid = 1;
    #1 check("R4 pull_ready empty", int'(pull_ready), 0);
    @(posedge clk); #1 pull_valid = 0;
    check("R4 used unchanged", int'(used_words), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule